// File: doc/BRIEF.md
# Look-Up Table with Upset Injection and Excitation Monitor

This block is an n-input look-up table whose configuration bits are loaded as one word. Its combinational output is the configuration bit selected by the current input vector. A single-event upset can be emulated: a strobe with a bit index inverts that one configuration bit in the working copy of the table. A fault-free shadow copy stays as it was loaded.

Two monitors run beside the table. The first records whether the input vector that selects the inverted entry has ever been applied, so an unexcited fault can be told apart from an excited one. The second compares the working output with the shadow output on every clock edge. Both flags are sticky. A cycle counter that runs from reset lets the block report the cycle at which the fault was first excited. These flags let a test campaign decide whether a chosen input sequence ever reaches an injected upset and whether the upset shows at the table output.

Top module: `seu_lut_monitor`

## Requirements
- R1: With no fault active, `data_o` equals bit `addr_i` of the loaded configuration word (bit i of `cfg_data_i` is the output for input vector value i).
- R2: A strobe on `inj_stb_i` takes effect at the next rising edge. From then on, `fault_act_o` is 1, `fault_idx_o` holds the strobed index, and only the entry at that index reads inverted. Every other entry reads its loaded value.
- R3: Only one entry is inverted at a time. A new injection restores the previously inverted entry and inverts the new one.
- R4: A configuration load (`cfg_we_i`) replaces the table at the next edge and cancels any active fault. When it coincides with an injection strobe, the load wins and no fault is active afterwards.
- R5: `excited_o` is set at an edge where a fault is active and `addr_i` equals `fault_idx_o`. While only other vectors are applied, it stays 0.
- R6: `mismatch_o` is set at an edge where the working output differs from the fault-free output for the applied vector.
- R7: Both flags hold once set until `clr_i` is sampled high, which clears them. `clr_i` takes priority over a set in the same cycle.
- R8: A free-running, saturating cycle counter starts at 0 on reset and advances once per edge. `first_exc_o` captures the counter's value at the edge where `excited_o` is first set, and it keeps that value through later excitations until `clr_i` returns it to 0.
- R9: After reset, the table is all zeros, no fault is active, and `excited_o`, `mismatch_o` and `first_exc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the configuration word |
| cfg_data_i | input | 2**N_IN | Configuration word, bit i for input vector i |
| inj_stb_i | input | 1 | Upset injection strobe |
| inj_idx_i | input | N_IN | Index of the entry to invert |
| addr_i | input | N_IN | Functional input vector |
| clr_i | input | 1 | Clear the sticky flags and the first-excitation cycle |
| data_o | output | 1 | Table output (working copy) |
| fault_act_o | output | 1 | An injected fault is active |
| fault_idx_o | output | N_IN | Index of the inverted entry |
| excited_o | output | 1 | Sticky: the inverted entry has been addressed |
| mismatch_o | output | 1 | Sticky: the working output differed from the fault-free one |
| first_exc_o | output | CNT_W | Cycle count at the first excitation |

## Verification
The bench loads several configuration words. For each one it injects a fault at every index, then sweeps every other input vector. A design that decodes the index wrongly, or that inverts more than one entry, shows a wrong output there, and a monitor that fires on a neighbouring vector sets the excited flag before the faulty vector is ever applied. Applying the faulty vector then checks the inverted output, both flags and the captured cycle. Holding that vector for another cycle catches a capture register that keeps updating. Further checks target a re-injection that leaves the old entry flipped, a clear that loses to a same-cycle set, and a load coinciding with a strobe that leaves a fault behind.

// File: rtl/seu_lut_pkg.sv
package seu_lut_pkg;
  typedef struct packed {
    logic excited;
    logic mismatch;
  } mon_flags_t;
endpackage

// File: rtl/lut_cfg_store.sv
module lut_cfg_store #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned TBL = 1 << N_IN
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [TBL-1:0] cfg_data_i,
  output logic [TBL-1:0] gold_o
);
  logic [TBL-1:0] gold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gold_q <= '0;
    else if (cfg_we_i) gold_q <= cfg_data_i;
  end

  assign gold_o = gold_q;
endmodule

// File: rtl/seu_flip_ctrl.sv
module seu_flip_ctrl #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned TBL = 1 << N_IN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic            inj_stb_i,
  input  logic [N_IN-1:0] inj_idx_i,
  output logic            act_o,
  output logic [N_IN-1:0] idx_o,
  output logic [TBL-1:0]  mask_o
);
  logic            act_q;
  logic [N_IN-1:0] idx_q;

  // a load scrubs the fault; a strobe replaces the old index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (cfg_we_i) begin
      act_q <= 1'b0;
    end else if (inj_stb_i) begin
      act_q <= 1'b1;
      idx_q <= inj_idx_i;
    end
  end

  for (genvar g = 0; g < TBL; g++) begin : g_mask
    assign mask_o[g] = act_q && (idx_q == N_IN'(g));
  end

  assign act_o = act_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/lut_read.sv
module lut_read #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned TBL = 1 << N_IN
) (
  input  logic [TBL-1:0]  gold_i,
  input  logic [TBL-1:0]  mask_i,
  input  logic [N_IN-1:0] addr_i,
  output logic            gold_bit_o,
  output logic            work_bit_o
);
  logic [TBL-1:0] work;

  for (genvar g = 0; g < TBL; g++) begin : g_work
    assign work[g] = gold_i[g] ^ mask_i[g];
  end

  assign gold_bit_o = gold_i[addr_i];
  assign work_bit_o = work[addr_i];
endmodule

// File: rtl/fault_monitor.sv
module fault_monitor
  import seu_lut_pkg::*;
#(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             act_i,
  input  logic [N_IN-1:0]  idx_i,
  input  logic [N_IN-1:0]  addr_i,
  input  logic             gold_bit_i,
  input  logic             work_bit_i,
  output mon_flags_t       flags_o,
  output logic [CNT_W-1:0] first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  mon_flags_t       flags_q;
  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] first_q;
  logic             hit;
  logic             diff;

  assign hit  = act_i && (addr_i == idx_i);
  assign diff = gold_bit_i ^ work_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cyc_q <= '0;
    else if (cyc_q != CNT_MAX) cyc_q <= cyc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      first_q <= '0;
    end else if (clr_i) begin
      flags_q <= '0;
      first_q <= '0;
    end else begin
      if (hit && !flags_q.excited) first_q <= cyc_q;
      flags_q.excited  <= flags_q.excited | hit;
      flags_q.mismatch <= flags_q.mismatch | diff;
    end
  end

  assign flags_o = flags_q;
  assign first_o = first_q;
endmodule

// File: rtl/seu_lut_monitor.sv
module seu_lut_monitor
  import seu_lut_pkg::*;
#(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned TBL  = 1 << N_IN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [TBL-1:0]   cfg_data_i,
  input  logic             inj_stb_i,
  input  logic [N_IN-1:0]  inj_idx_i,
  input  logic [N_IN-1:0]  addr_i,
  input  logic             clr_i,
  output logic             data_o,
  output logic             fault_act_o,
  output logic [N_IN-1:0]  fault_idx_o,
  output logic             excited_o,
  output logic             mismatch_o,
  output logic [CNT_W-1:0] first_exc_o
);
  logic [TBL-1:0]  gold_w;
  logic [TBL-1:0]  mask_w;
  logic            act_w;
  logic [N_IN-1:0] idx_w;
  logic            gold_bit_w;
  logic            work_bit_w;
  mon_flags_t      flags_w;

  lut_cfg_store #(.N_IN(N_IN)) u_store (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_data_i, .gold_o(gold_w)
  );

  seu_flip_ctrl #(.N_IN(N_IN)) u_flip (
    .clk_i, .rst_ni, .cfg_we_i, .inj_stb_i, .inj_idx_i,
    .act_o(act_w), .idx_o(idx_w), .mask_o(mask_w)
  );

  lut_read #(.N_IN(N_IN)) u_read (
    .gold_i(gold_w), .mask_i(mask_w), .addr_i,
    .gold_bit_o(gold_bit_w), .work_bit_o(work_bit_w)
  );

  fault_monitor #(.N_IN(N_IN), .CNT_W(CNT_W)) u_mon (
    .clk_i, .rst_ni, .clr_i, .act_i(act_w), .idx_i(idx_w), .addr_i,
    .gold_bit_i(gold_bit_w), .work_bit_i(work_bit_w),
    .flags_o(flags_w), .first_o(first_exc_o)
  );

  assign data_o      = work_bit_w;
  assign fault_act_o = act_w;
  assign fault_idx_o = idx_w;
  assign excited_o   = flags_w.excited;
  assign mismatch_o  = flags_w.mismatch;
endmodule

// File: rtl/seu_lut_monitor_chk.sv
module seu_lut_monitor_chk #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             inj_stb_i,
  input logic [N_IN-1:0]  inj_idx_i,
  input logic [N_IN-1:0]  addr_i,
  input logic             clr_i,
  input logic             data_o,
  input logic             gold_bit_i,
  input logic             fault_act_o,
  input logic [N_IN-1:0]  fault_idx_o,
  input logic             excited_o,
  input logic             mismatch_o,
  input logic [CNT_W-1:0] first_exc_o
);
  assert_inject_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_stb_i && !cfg_we_i |=> fault_act_o && fault_idx_o == $past(inj_idx_i));

  assert_load_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !fault_act_o);

  assert_excite_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_act_o && addr_i == fault_idx_o && !clr_i |=> excited_o);

  assert_no_spurious_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !excited_o && !(fault_act_o && addr_i == fault_idx_o) |=> !excited_o);

  assert_mismatch_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o != gold_bit_i && !clr_i |=> mismatch_o);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (excited_o || mismatch_o) && !clr_i |=> excited_o == $past(excited_o) ||
                                            mismatch_o == $past(mismatch_o) ? 1'b1 : 1'b0);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !excited_o && !mismatch_o && first_exc_o == '0);

  assert_first_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excited_o && !clr_i |=> $stable(first_exc_o));
endmodule

bind seu_lut_monitor seu_lut_monitor_chk #(.N_IN(N_IN), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .inj_stb_i(inj_stb_i),
  .inj_idx_i(inj_idx_i), .addr_i(addr_i), .clr_i(clr_i), .data_o(data_o),
  .gold_bit_i(gold_bit_w), .fault_act_o(fault_act_o), .fault_idx_o(fault_idx_o),
  .excited_o(excited_o), .mismatch_o(mismatch_o), .first_exc_o(first_exc_o)
);

// File: tb/seu_lut_monitor_bench.sv
module seu_lut_monitor_bench;
  localparam int N_IN   = 4;
  localparam int CNT_W  = 16;
  localparam int TBL    = 1 << N_IN;
  localparam int CLK_PD = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [TBL-1:0]   cfg_data_i = '0;
  logic             inj_stb_i = 1'b0;
  logic [N_IN-1:0]  inj_idx_i = '0;
  logic [N_IN-1:0]  addr_i = '0;
  logic             clr_i = 1'b0;
  logic             data_o;
  logic             fault_act_o;
  logic [N_IN-1:0]  fault_idx_o;
  logic             excited_o;
  logic             mismatch_o;
  logic [CNT_W-1:0] first_exc_o;

  int errors = 0;
  int checks = 0;
  int bcyc = 0;
  bit done = 1'b0;

  always #(CLK_PD/2) clk_i = ~clk_i;

  // edges since reset release, per R8
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) bcyc <= 0;
    else         bcyc <= bcyc + 1;

  seu_lut_monitor #(.N_IN(N_IN), .CNT_W(CNT_W)) u_seu_lut_monitor (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_data_i, .inj_stb_i, .inj_idx_i,
    .addr_i, .clr_i, .data_o, .fault_act_o, .fault_idx_o, .excited_o,
    .mismatch_o, .first_exc_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic load(input logic [TBL-1:0] w);
    cfg_data_i = w; cfg_we_i = 1'b1; clr_i = 1'b1;
    step();
    cfg_we_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic inject(input int idx, input int park);
    inj_idx_i = N_IN'(idx); inj_stb_i = 1'b1; addr_i = N_IN'(park);
    step();
    inj_stb_i = 1'b0;
  endtask

  initial begin
    logic [TBL-1:0] cfgs [4];
    cfgs[0] = 16'hFFFE; cfgs[1] = 16'hA5C3; cfgs[2] = 16'h0000; cfgs[3] = 16'h6996;

    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9 reset state
    #1;
    chk(data_o == 1'b0 && fault_act_o == 1'b0, "R9 table/fault", {data_o, fault_act_o}, 0);
    chk(!excited_o && !mismatch_o && first_exc_o == '0, "R9 flags",
        {excited_o, mismatch_o, first_exc_o}, 0);

    foreach (cfgs[c]) begin
      for (int idx = 0; idx < TBL; idx++) begin
        int exp_first;
        load(cfgs[c]);
        chk(!fault_act_o, "R4 load leaves no fault", fault_act_o, 0);
        for (int a = 0; a < TBL; a++) begin
          addr_i = N_IN'(a); #1;
          chk(data_o == cfgs[c][a], "R1 clean read", data_o, cfgs[c][a]);
        end
        inject(idx, idx ^ 1);
        chk(fault_act_o && fault_idx_o == N_IN'(idx), "R2 inject index",
            fault_idx_o, idx);
        for (int a = 0; a < TBL; a++) begin
          if (a == idx) continue;
          addr_i = N_IN'(a); #1;
          chk(data_o == cfgs[c][a], "R2 other entry intact", data_o, cfgs[c][a]);
          step();
        end
        chk(!excited_o && !mismatch_o, "R5 unexcited stays clear",
            {excited_o, mismatch_o}, 0);
        addr_i = N_IN'(idx); #1;
        chk(data_o == !cfgs[c][idx], "R2 flipped entry", data_o, !cfgs[c][idx]);
        exp_first = bcyc;
        step();
        chk(excited_o, "R5 excited", excited_o, 1);
        chk(mismatch_o, "R6 mismatch", mismatch_o, 1);
        chk(first_exc_o == CNT_W'(exp_first), "R8 first cycle", first_exc_o, exp_first);
        step();
        chk(first_exc_o == CNT_W'(exp_first), "R8 first held", first_exc_o, exp_first);
        addr_i = N_IN'(idx ^ 1);
        step(); step();
        chk(excited_o && mismatch_o, "R7 sticky", {excited_o, mismatch_o}, 3);

        if (idx % 4 == 0) begin
          int nidx = idx ^ (TBL - 1);
          inject(nidx, idx ^ 2);
          addr_i = N_IN'(idx); #1;
          chk(data_o == cfgs[c][idx], "R3 old entry restored", data_o, cfgs[c][idx]);
          addr_i = N_IN'(nidx); #1;
          chk(data_o == !cfgs[c][nidx], "R3 new entry flipped", data_o, !cfgs[c][nidx]);
          clr_i = 1'b1;
          step();
          clr_i = 1'b0;
          chk(!excited_o && !mismatch_o && first_exc_o == '0, "R7 clear beats set",
              {excited_o, mismatch_o, first_exc_o}, 0);
          addr_i = N_IN'(idx);
          step();
          chk(!excited_o && !mismatch_o, "R7 stays clear", {excited_o, mismatch_o}, 0);
          // load coinciding with a strobe
          cfg_data_i = cfgs[c]; cfg_we_i = 1'b1; inj_stb_i = 1'b1;
          inj_idx_i = N_IN'(idx);
          step();
          cfg_we_i = 1'b0; inj_stb_i = 1'b0;
          chk(!fault_act_o, "R4 load wins over strobe", fault_act_o, 0);
          #1;
          chk(data_o == cfgs[c][idx], "R4 no flip after load", data_o, cfgs[c][idx]);
          step();
          chk(!excited_o, "R4 no excitation after load", excited_o, 0);
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule